// File: doc/BRIEF.md
# RC-6 Infrared Frame Receiver

This block takes an already demodulated infrared line, as seen at the output of a receiver module, and decodes RC-6 frames from it. The line passes through a two-flop synchronizer. The block times every interval between edges on the system clock and rounds it to whole half-bit units, where `HALF_CLKS` clocks make one unit. A leader of six active units followed by two idle units opens a frame. The block then rebuilds the Manchester bit stream half by half, including the toggle bit, whose halves are each two units long. From that stream it separates the start bit, the mode, the toggle, the address and the data field.

A frame ends when the line stays quiet for six units. At that point the block either pulses `rx_valid` for one clock and loads the decoded fields into the output registers, or pulses `rx_err`. The output registers keep their values until the next good frame. Line polarity can be fixed or learned from the leader. `HALF_CLKS` must be at least 8, and 444 suits a 1 MHz clock.

Top module: `rc6_rx`

## Requirements
- R1: An edge-to-edge interval of D clocks counts as round(D / HALF_CLKS) units, and an exact half-unit remainder rounds up. A whole frame whose data intervals are all shifted by any offset from -HALF_CLKS/2 up to HALF_CLKS/2 - 1 clocks decodes the same as an exact one.
- R2: A frame opens only on an active interval of 6 units directly followed by an idle interval of 2 units. A leader of any other length produces neither `rx_valid` nor `rx_err`.
- R3: The first bit after the leader is the start bit, and only a value of 1 is accepted. A frame sent with start bit 0 produces no `rx_valid`.
- R4: A bit with value 1 is active in its first half and idle in its second half. After the start bit come 3 mode bits, MSB first, then the toggle bit, each half of which lasts 2 units. These appear on `rx_mode` and `rx_toggle`.
- R5: In mode 0, a frame is good only with exactly 22 bits counting the leader as bit 0. Bits 6..13 give an 8-bit address and bits 14..21 give 8 data bits, both MSB first. Any other length gives `rx_err`.
- R6: In mode 6, when bit 6 is 0, the address is 8 bits wide (bits 6..13) and every later bit is data, MSB first, with the data count in `rx_data_bits`. At least one data bit is needed.
- R7: In mode 6, when bit 6 is 1, the address is 16 bits wide (bits 6..21), `rx_addr_long` is 1, and data starts at bit 22.
- R8: A data field of up to DATA_W bits is accepted. The DATA_W+1-th data bit ends the frame with `rx_err`.
- R9: In the data phase, an interval that rounds to 0 or to more than 3 units, or a half bit at the wrong level, discards the frame with `rx_err`. The receiver then returns to leader search, so the next good frame decodes.
- R10: `pol_sel` 2'b01 sets the line to active-high and 2'b10 sets it to active-low. Any other value takes the active level from the leader's 6-unit interval. With fixed polarity, a leader at the wrong level is ignored.
- R11: A frame closes 6 quiet units after its last edge with exactly one single-cycle `rx_valid` or `rx_err`. The field outputs change only on `rx_valid`.
- R12: Modes other than 0 and 6 end with `rx_err`. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line, asynchronous |
| pol_sel | input | 2 | 01 active-high, 10 active-low, other auto |
| rx_valid | output | 1 | One-cycle pulse for a good frame |
| rx_err | output | 1 | One-cycle pulse for a rejected frame |
| rx_mode | output | 3 | Mode field of last good frame |
| rx_toggle | output | 1 | Toggle bit of last good frame |
| rx_addr | output | 16 | Address, right aligned |
| rx_addr_long | output | 1 | Address was 16 bits |
| rx_data | output | DATA_W | Data field, right aligned |
| rx_data_bits | output | $clog2(DATA_W+1) | Number of data bits |
| rx_frame_bits | output | 7 | Total bits including the leader |

## Verification
The bench sweeps every mode and every short-form data length from 1 to 33. A design that miscounts the double-width toggle shifts every later field. A design that truncates instead of rounding fails the timing-offset sweep at the -HALF_CLKS/2 offset. A design without the 32-bit cap accepts the 33-bit frame. The bench also sends a leader at the wrong polarity, a broken leader, an illegal interval followed by a good frame, and an error frame after a good one. A design that does not restart, or that overwrites the held fields, is caught by these.

// File: rtl/rc6_rx.sv
module rc6_rx #(
  parameter int HALF_CLKS = 444,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ir_in,
  input  logic [1:0]                   pol_sel,
  output logic                         rx_valid,
  output logic                         rx_err,
  output logic [2:0]                   rx_mode,
  output logic                         rx_toggle,
  output logic [15:0]                  rx_addr,
  output logic                         rx_addr_long,
  output logic [DATA_W-1:0]            rx_data,
  output logic [$clog2(DATA_W+1)-1:0]  rx_data_bits,
  output logic [6:0]                   rx_frame_bits
);
  localparam int CW  = $clog2(HALF_CLKS);
  localparam int DBW = $clog2(DATA_W+1);
  localparam logic [CW-1:0] LAST_SUB = CW'(HALF_CLKS - 1);
  localparam logic [CW:0]   HALF_V   = (CW+1)'(HALF_CLKS);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_FIN} st_t;

  logic [2:0] sync;
  logic [CW-1:0] sub;
  logic [2:0] units;
  st_t st;
  logic act, prev_raw, plev, first, w_tog, w_long;
  logic [3:0] prev_n;
  logic [1:0] pend, ucnt;
  logic [6:0] bidx;
  logic [2:0] w_mode;
  logic [15:0] w_addr;
  logic [DATA_W-1:0] w_data;
  logic [DBW-1:0] w_dbits;

  wire edge_det = sync[1] ^ sync[2];
  wire tick     = (sub == LAST_SUB);
  wire [3:0] n_units = {1'b0, units} + {3'b0, ({sub, 1'b0} >= HALF_V)};
  wire timeout  = tick && (units == 3'd5);
  wire lvl_now  = (sync[2] == act);
  wire pol_ok   = (pol_sel == 2'b01) ? prev_raw :
                  (pol_sel == 2'b10) ? !prev_raw : 1'b1;
  wire leader   = (prev_n == 4'd6) && (n_units == 4'd2) && pol_ok;

  wire [1:0] half_u  = (bidx == 7'd5) ? 2'd2 : 2'd1;
  wire [1:0] last_u  = (bidx == 7'd5) ? 2'd3 : 2'd1;
  wire exp_lv        = (ucnt < half_u) ? first : !first;
  wire bad_half      = (ucnt != 2'd0) && (plev != exp_lv);
  wire is_addr       = (bidx < 7'd14) || (w_long && (bidx < 7'd22));
  wire frame_ok      = (ucnt == 2'd0) &&
                       (((w_mode == 3'd0) && (bidx == 7'd22)) ||
                        ((w_mode == 3'd6) && (w_dbits != '0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= '0;
      sub   <= '0;
      units <= 3'd7;
    end else begin
      sync <= {sync[1:0], ir_in};
      if (edge_det) begin
        sub   <= CW'(1);
        units <= 3'd0;
      end else if (tick) begin
        sub   <= '0;
        units <= (units == 3'd7) ? units : units + 3'd1;
      end else begin
        sub <= sub + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; act <= 1'b1; prev_raw <= 1'b0; prev_n <= '0;
      pend <= '0; plev <= 1'b0; ucnt <= '0; first <= 1'b0; bidx <= '0;
      w_mode <= '0; w_tog <= 1'b0; w_addr <= '0; w_long <= 1'b0;
      w_data <= '0; w_dbits <= '0;
      rx_valid <= 1'b0; rx_err <= 1'b0; rx_mode <= '0; rx_toggle <= 1'b0;
      rx_addr <= '0; rx_addr_long <= 1'b0; rx_data <= '0;
      rx_data_bits <= '0; rx_frame_bits <= '0;
    end else begin
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      if (edge_det) begin
        prev_n   <= n_units;
        prev_raw <= sync[2];
      end
      if (st == S_IDLE) begin
        if (edge_det && leader) begin
          st <= S_DATA; act <= prev_raw; pend <= '0; ucnt <= '0;
          bidx <= 7'd1; w_mode <= '0; w_tog <= 1'b0; w_addr <= '0;
          w_long <= 1'b0; w_data <= '0; w_dbits <= '0;
        end
      end else if (st == S_DATA && edge_det) begin
        if (n_units == 4'd0 || n_units > 4'd3) begin
          rx_err <= 1'b1; st <= S_IDLE;
        end else begin
          pend <= n_units[1:0];
          plev <= lvl_now;
        end
      end else if (pend != 2'd0) begin
        pend <= pend - 2'd1;
        if (bad_half) begin
          rx_err <= 1'b1; st <= S_IDLE; pend <= '0;
        end else if (ucnt == last_u) begin
          ucnt <= '0;
          bidx <= bidx + 7'd1;
          if (bidx == 7'd1) begin
            if (!first) begin rx_err <= 1'b1; st <= S_IDLE; pend <= '0; end
          end else if (bidx < 7'd5) begin
            w_mode <= {w_mode[1:0], first};
          end else if (bidx == 7'd5) begin
            w_tog <= first;
          end else if (is_addr) begin
            if (bidx == 7'd6) w_long <= (w_mode == 3'd6) && first;
            w_addr <= {w_addr[14:0], first};
          end else if (w_dbits == DBW'(DATA_W)) begin
            rx_err <= 1'b1; st <= S_IDLE; pend <= '0;
          end else begin
            w_data  <= {w_data[DATA_W-2:0], first};
            w_dbits <= w_dbits + DBW'(1);
          end
        end else begin
          if (ucnt == 2'd0) first <= plev;
          ucnt <= ucnt + 2'd1;
        end
      end else if (st == S_DATA && timeout) begin
        st <= S_FIN;
        if (ucnt != 2'd0) begin pend <= 2'd1; plev <= 1'b0; end
      end else if (st == S_FIN) begin
        st <= S_IDLE;
        if (frame_ok) begin
          rx_valid <= 1'b1; rx_mode <= w_mode; rx_toggle <= w_tog;
          rx_addr <= w_addr; rx_addr_long <= w_long; rx_data <= w_data;
          rx_data_bits <= w_dbits; rx_frame_bits <= bidx;
        end else begin
          rx_err <= 1'b1;
        end
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_err)); // R11
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R11
  AST_QUIET_END: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (units >= 3'd6)); // R11
  AST_MODE0_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_mode == 3'd0) |-> (rx_frame_bits == 7'd22)); // R5
  AST_LONG_MODE6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_addr_long) |-> (rx_mode == 3'd6)); // R7
  AST_DATA_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_data_bits <= DBW'(DATA_W))); // R8
  AST_GOOD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_mode == 3'd0 || rx_mode == 3'd6)); // R12
endmodule

// File: tb/tb_rc6_rx.sv
module tb_rc6_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0, ir_in = 1'b0;
  logic [1:0] pol_sel = 2'b00;
  logic rx_valid, rx_err, rx_toggle, rx_addr_long;
  logic [2:0] rx_mode;
  logic [15:0] rx_addr;
  logic [DW-1:0] rx_data;
  logic [5:0] rx_data_bits;
  logic [6:0] rx_frame_bits;

  rc6_rx #(.HALF_CLKS(HALF), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .pol_sel(pol_sel),
    .rx_valid(rx_valid), .rx_err(rx_err), .rx_mode(rx_mode),
    .rx_toggle(rx_toggle), .rx_addr(rx_addr), .rx_addr_long(rx_addr_long),
    .rx_data(rx_data), .rx_data_bits(rx_data_bits),
    .rx_frame_bits(rx_frame_bits));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, nv = 0, ne = 0;
  logic lv [0:255];
  int nu = 0, lead = 8;
  logic act_lvl = 1'b1;

  always @(negedge clk) begin
    if (rx_valid) nv++;
    if (rx_err) ne++;
  end

  task automatic chk(string req, string what, longint a, longint e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  task automatic drive(bit v, int n);
    ir_in = v ? act_lvl : !act_lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic put_units(bit v, int n);
    for (int i = 0; i < n; i++) begin lv[nu] = v; nu++; end
  endtask

  task automatic put_bit(bit b, int l);
    put_units(b, l);
    put_units(!b, l);
  endtask

  task automatic build(int la, int lb, bit st, logic [2:0] md, bit tg,
                       logic [15:0] ad, int alen, logic [63:0] dt, int dlen);
    nu = 0;
    put_units(1'b1, la);
    put_units(1'b0, lb);
    lead = la + lb;
    put_bit(st, 1);
    for (int i = 2; i >= 0; i--) put_bit(md[i], 1);
    put_bit(tg, 2);
    for (int i = alen - 1; i >= 0; i--) put_bit(ad[i], 1);
    for (int i = dlen - 1; i >= 0; i--) put_bit(dt[i], 1);
  endtask

  task automatic send(int jit);
    int i, j;
    i = 0;
    while (i < nu) begin
      j = i;
      while (j < nu && lv[j] == lv[i]) j++;
      drive(lv[i], (j - i) * HALF + ((i >= lead) ? jit : 0));
      i = j;
    end
    drive(1'b0, 14 * HALF);
  endtask

  task automatic frame(string req, bit pol_ok, bit st, logic [2:0] md, bit tg,
                       logic [15:0] ad, int alen, logic [63:0] dt, int dlen,
                       int jit, int la, int lb);
    int v0, e0;
    bit det, ok;
    logic [63:0] dm;
    v0 = nv; e0 = ne;
    drive(1'b0, 10 * HALF);
    build(la, lb, st, md, tg, ad, alen, dt, dlen);
    send(jit);
    dm = (dlen >= 64) ? dt : (dt & ((64'd1 << dlen) - 64'd1));
    det = pol_ok && st && la == 6 && lb == 2;
    ok = det && dlen <= DW &&
         ((md == 3'd0 && alen == 8 && dlen == 8) ||
          (md == 3'd6 && dlen >= 1 &&
           ((alen == 8 && !ad[7]) || (alen == 16 && ad[15]))));
    chk(req, "valid count", nv - v0, ok ? 1 : 0);
    chk(req, "err count", ne - e0, (det && !ok) ? 1 : 0);
    if (ok) begin
      chk(req, "mode", rx_mode, md);
      chk(req, "toggle", rx_toggle, tg);
      chk(req, "addr", rx_addr, (alen == 8) ? {8'h00, ad[7:0]} : ad);
      chk(req, "addr_long", rx_addr_long, alen == 16);
      chk(req, "data", rx_data, dm);
      chk(req, "data_bits", rx_data_bits, dlen);
      chk(req, "frame_bits", rx_frame_bits, 6 + alen + dlen);
    end
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    int v0, e0;
    logic [15:0] hold_a;
    logic [DW-1:0] hold_d;
    repeat (3) @(negedge clk);
    chk("R12", "reset valid", rx_valid, 0);
    chk("R12", "reset addr", rx_addr, 0);
    chk("R12", "reset data", rx_data, 0);
    chk("R12", "reset frame_bits", rx_frame_bits, 0);
    rst_n = 1'b1;
    drive(1'b0, 4);

    for (int m = 0; m < 8; m++)
      frame("R4", 1, 1, 3'(m), m[0], 16'h005A, 8, 64'h00C3 ^ 64'(m * 17), 8, 0, 6, 2);
    frame("R12", 1, 1, 3'd5, 1'b0, 16'h0011, 8, 64'h0022, 8, 0, 6, 2);
    frame("R5", 1, 1, 3'd0, 1'b1, 16'h00A7, 8, 64'h0041, 7, 0, 6, 2);
    frame("R5", 1, 1, 3'd0, 1'b0, 16'h00A7, 8, 64'h01F1, 9, 0, 6, 2);
    frame("R5", 1, 1, 3'd0, 1'b0, 16'h00FF, 8, 64'h0080, 8, 0, 6, 2);

    for (int n = 1; n <= 33; n++)
      frame((n > 32) ? "R8" : "R6", 1, 1, 3'd6, n[1], 16'h0036, 8,
            64'hA5C3_96E1_0F1E_2D3C ^ 64'(n), n, 0, 6, 2);

    for (int k = 0; k < 7; k++) begin
      int lens [7] = '{1, 8, 16, 24, 31, 32, 33};
      frame((lens[k] > 32) ? "R8" : "R7", 1, 1, 3'd6, k[0], 16'h8000 | 16'(k * 4099),
            16, 64'h1357_9BDF_2468_ACE0 ^ 64'(k), lens[k], 0, 6, 2);
    end

    for (int j = -HALF / 2; j < HALF / 2; j++)
      frame("R1", 1, 1, 3'd0, j[0], 16'h00B4, 8, 64'h6D, 8, j, 6, 2);

    pol_sel = 2'b01; act_lvl = 1'b1;
    frame("R10", 1, 1, 3'd0, 1'b1, 16'h0012, 8, 64'h34, 8, 0, 6, 2);
    pol_sel = 2'b10; act_lvl = 1'b0;
    frame("R10", 1, 1, 3'd0, 1'b0, 16'h0056, 8, 64'h78, 8, 0, 6, 2);
    pol_sel = 2'b01; act_lvl = 1'b0;
    frame("R10", 0, 1, 3'd0, 1'b0, 16'h0056, 8, 64'h78, 8, 0, 6, 2);
    pol_sel = 2'b10; act_lvl = 1'b1;
    frame("R10", 0, 1, 3'd0, 1'b0, 16'h0056, 8, 64'h78, 8, 0, 6, 2);
    pol_sel = 2'b00; act_lvl = 1'b0;
    frame("R10", 1, 1, 3'd6, 1'b1, 16'h0021, 8, 64'h5, 3, 0, 6, 2);
    act_lvl = 1'b1;

    frame("R3", 1, 0, 3'd0, 1'b0, 16'h0033, 8, 64'h44, 8, 0, 6, 2);
    frame("R2", 1, 1, 3'd0, 1'b0, 16'h0033, 8, 64'h44, 8, 0, 5, 2);
    frame("R2", 1, 1, 3'd0, 1'b0, 16'h0033, 8, 64'h44, 8, 0, 6, 3);

    v0 = nv; e0 = ne;
    drive(1'b0, 10 * HALF);
    nu = 0; put_units(1'b1, 6); put_units(1'b0, 2); lead = 8;
    put_units(1'b1, 1); put_units(1'b0, 4); put_units(1'b1, 1);
    send(0);
    chk("R9", "valid count", nv - v0, 0);
    chk("R9", "err count", ne - e0, 1);
    frame("R9", 1, 1, 3'd0, 1'b1, 16'h009C, 8, 64'hE2, 8, 0, 6, 2);

    hold_a = rx_addr; hold_d = rx_data;
    frame("R11", 1, 1, 3'd2, 1'b0, 16'h0017, 8, 64'h99, 8, 0, 6, 2);
    chk("R11", "held addr", rx_addr, hold_a);
    chk("R11", "held data", rx_data, hold_d);

    report();
    $finish;
  end
endmodule